// File: doc/BRIEF.md
# UART Receive Character Buffer with Automatic Request-to-Send

This block sits behind the bit-level deserializer of one UART channel. Each received character arrives on a one-cycle strobe together with three error flags: framing, parity and break. The character and its flags are stored in an eight-entry first-in first-out buffer. The host sees the oldest character and the current fill level at all times, and removes that character with a read strobe.

Error status is reported in one of two modes. In per-character mode the status outputs show the flags of the entry at the head only. In accumulate mode each flag is sticky. It collects every character that has reached the head since the last clear-errors command. A write into a full buffer drops the character and sets a sticky overrun flag.

The active-low request-to-send output normally follows explicit raise and drop commands. With automatic flow control enabled, the output is dropped when a start bit is detected and the buffer already holds six or more characters (three-quarters of its depth). It is raised again by itself once the fill falls below six.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the buffer is empty (fill 0, head_valid 0), all status outputs and overrun are 0, and rts_n is 1 (negated).
- R2: Characters leave in the order they were written; head_data shows the oldest stored character and fill gives the occupancy, from 0 to 8.
- R3: A character strobed in while fill is 8 is discarded, leaving fill and head unchanged, and overrun becomes 1 on the next cycle; overrun stays 1 until err_clr and returns to 0 on the cycle after err_clr.
- R4: With block_mode 0, stat_frm, stat_par and stat_brk equal the flags stored with the head character, and are all 0 when the buffer is empty.
- R5: With block_mode 1, each status bit is the OR of that flag over every character that became the head since the last err_clr. A character is counted once, when it becomes the head. err_clr zeroes the collected status, and the status stays set when the buffer empties.
- R6: With auto_rts 1, a start_det pulse while fill is 6 or more sets rts_n to 1 on the next cycle.
- R7: After an automatic drop, rts_n returns to 0 one cycle after fill has fallen below 6. It stays 1 while fill remains at 6 or more.
- R8: rts_on sets rts_n to 0 and rts_off sets it to 1, each on the next cycle. With auto_rts 0, start_det has no effect on rts_n.
- R9: A read strobe on an empty buffer changes nothing, and a start_det pulse while fill is below 6 leaves rts_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| rx_frm | input | 1 | Framing error flag of the character |
| rx_par | input | 1 | Parity error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| start_det | input | 1 | Start bit detected pulse |
| rd_en | input | 1 | Host read strobe; removes the head character |
| err_clr | input | 1 | Clear collected status and overrun |
| rts_on | input | 1 | Command: assert request-to-send (rts_n to 0) |
| rts_off | input | 1 | Command: negate request-to-send (rts_n to 1) |
| auto_rts | input | 1 | Enable automatic flow control |
| block_mode | input | 1 | 0 = per-character status, 1 = accumulated status |
| head_data | output | 8 | Oldest stored character |
| head_valid | output | 1 | Buffer holds at least one character |
| stat_frm | output | 1 | Framing error status |
| stat_par | output | 1 | Parity error status |
| stat_brk | output | 1 | Break status |
| overrun | output | 1 | Sticky overrun flag |
| fill | output | 4 | Number of stored characters |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
The assertions assume that rts_on and rts_off are never high in the same cycle. They also assume every strobe lasts exactly one clock, so a single start bit cannot cause two drops. The stimulus drives each command alone and returns every strobe to 0 on the following falling edge. The read strobe is raised only when the test intends an actual removal, except in the one deliberate empty-read case.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_flags_t;

  // Occupancy at which automatic flow control drops request-to-send.
  function automatic int unsigned three_quarter(input int unsigned depth);
    return (depth * 3) / 4;
  endfunction
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] wr_data,
  input  rx_flags_t     wr_flags,
  output logic [DW-1:0] head_data,
  output rx_flags_t     head_flags,
  output rx_flags_t     next_flags,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          ovf_evt
);
  logic [DW-1:0] mem_d [DEPTH];
  rx_flags_t     mem_f [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic          full, empty;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign ovf_evt = push_req && full;

  assign head_data  = mem_d[rd_ptr];
  assign head_flags = mem_f[rd_ptr];
  assign next_flags = mem_f[step(rd_ptr)];

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_d[wr_ptr] <= wr_data;
      mem_f[wr_ptr] <= wr_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R3
  full_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt && !pop_req |=> count == CW'(DEPTH));

  // R9
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop_req && !push_req |=> count == '0);
endmodule

// File: rtl/rxbuf_errstat.sv
module rxbuf_errstat
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          ovf_evt,
  input  logic [CW-1:0] count,
  input  rx_flags_t     wr_flags,
  input  rx_flags_t     head_flags,
  input  rx_flags_t     next_flags,
  input  logic          block_mode,
  input  logic          err_clr,
  output rx_flags_t     stat,
  output logic          overrun
);
  rx_flags_t acc;
  logic      head_new;
  rx_flags_t arriving;
  logic      from_queue;

  // A new head comes either from the queue behind a read, or from the
  // incoming write when the head slot is (or becomes) vacant.
  assign from_queue = pop_ok && (count > CW'(1));
  assign head_new   = from_queue ||
                      (push_ok && ((count == '0) || (pop_ok && count == CW'(1))));
  assign arriving   = from_queue ? next_flags : wr_flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      overrun <= 1'b0;
    end else begin
      acc     <= (err_clr ? rx_flags_t'('0) : acc) |
                 (head_new ? arriving : rx_flags_t'('0));
      overrun <= (overrun && !err_clr) || ovf_evt;
    end
  end

  always_comb begin
    if (block_mode)         stat = acc;
    else if (count != '0)   stat = head_flags;
    else                    stat = '0;
  end

  // R3
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> overrun);

  // R5
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !head_new |=> acc == '0);

  // R5
  acc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (acc & $past(acc)) == $past(acc));
endmodule

// File: rtl/rxbuf_rts.sv
module rxbuf_rts
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam logic [CW-1:0] THR = CW'(three_quarter(DEPTH))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_en,
  input  logic          start_det,
  input  logic          cmd_on,
  input  logic          cmd_off,
  input  logic [CW-1:0] count,
  output logic          rts_n
);
  logic hold;
  logic auto_drop, auto_raise;

  assign auto_drop  = auto_en && start_det && (count >= THR);
  assign auto_raise = auto_en && hold && (count < THR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rts_n <= 1'b1;
      hold  <= 1'b0;
    end else if (cmd_off) begin
      rts_n <= 1'b1;
      hold  <= 1'b0;
    end else if (cmd_on) begin
      rts_n <= 1'b0;
      hold  <= 1'b0;
    end else if (auto_drop) begin
      rts_n <= 1'b1;
      hold  <= 1'b1;
    end else if (auto_raise) begin
      rts_n <= 1'b0;
      hold  <= 1'b0;
    end
  end

  // R6
  auto_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en && start_det && count >= THR && !cmd_on && !cmd_off |=> rts_n);

  // R8
  manual_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en && !cmd_on && !cmd_off |=> $stable(rts_n));

  // R8
  cmd_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on && !cmd_off |=> !rts_n);

  // R7
  no_early_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_n && count >= THR && !cmd_on |=> rts_n);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import rxbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_frm,
  input  logic       rx_par,
  input  logic       rx_brk,
  input  logic       start_det,
  input  logic       rd_en,
  input  logic       err_clr,
  input  logic       rts_on,
  input  logic       rts_off,
  input  logic       auto_rts,
  input  logic       block_mode,
  output logic [7:0] head_data,
  output logic       head_valid,
  output logic       stat_frm,
  output logic       stat_par,
  output logic       stat_brk,
  output logic       overrun,
  output logic [3:0] fill,
  output logic       rts_n
);
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  rx_flags_t     in_flags, head_flags, next_flags, stat;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok, ovf_evt;

  assign in_flags = '{brk: rx_brk, par: rx_par, frm: rx_frm};

  rxbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_req(rx_valid), .pop_req(rd_en),
    .wr_data(rx_data), .wr_flags(in_flags), .head_data(head_data),
    .head_flags(head_flags), .next_flags(next_flags), .count(count),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf_evt(ovf_evt)
  );

  rxbuf_errstat #(.DEPTH(DEPTH)) u_errstat (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop_ok(pop_ok),
    .ovf_evt(ovf_evt), .count(count), .wr_flags(in_flags),
    .head_flags(head_flags), .next_flags(next_flags),
    .block_mode(block_mode), .err_clr(err_clr), .stat(stat),
    .overrun(overrun)
  );

  rxbuf_rts #(.DEPTH(DEPTH)) u_rts (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_rts), .start_det(start_det),
    .cmd_on(rts_on), .cmd_off(rts_off), .count(count), .rts_n(rts_n)
  );

  assign head_valid = (count != '0);
  assign fill       = 4'(count);
  assign stat_frm   = stat.frm;
  assign stat_par   = stat.par;
  assign stat_brk   = stat.brk;

  // R1
  valid_matches_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_valid == (fill != 4'd0));
endmodule

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_frm = 0, rx_par = 0, rx_brk = 0, start_det = 0;
  logic rd_en = 0, err_clr = 0, rts_on = 0, rts_off = 0, auto_rts = 0, block_mode = 0;
  logic [7:0] rx_data = '0;
  logic [7:0] head_data;
  logic head_valid, stat_frm, stat_par, stat_brk, overrun, rts_n;
  logic [3:0] fill;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  uart_rx_buffer u_uart_rx_buffer (.*);

  // {brk, par, frm, data}
  localparam logic [10:0] VEC [8] = '{
    11'h0_41, 11'h1_5A, 11'h2_00, 11'h4_FF,
    11'h3_13, 11'h0_7E, 11'h7_C4, 11'h5_2B};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    rx_valid = 0; start_det = 0; rd_en = 0; err_clr = 0; rts_on = 0; rts_off = 0;
  endtask

  task automatic push(input logic [10:0] v);
    {rx_brk, rx_par, rx_frm, rx_data} = v;
    rx_valid = 1;
    cyc();
  endtask

  task automatic pop();
    rd_en = 1;
    cyc();
  endtask

  function automatic logic [2:0] st();
    return {stat_brk, stat_par, stat_frm};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 fill", fill, 0);
    chk("R1 head_valid", head_valid, 0);
    chk("R1 status", {overrun, st()}, 0);
    chk("R1 rts_n", rts_n, 1);

    // R2 fill grows with each write
    for (int i = 0; i < 8; i++) begin
      push(VEC[i]);
      chk("R2 fill", fill, i + 1);
    end
    // R3 write at full
    push(11'h0_99);
    chk("R3 fill after overrun", fill, 8);
    chk("R3 overrun set", overrun, 1);
    chk("R3 head kept", head_data, VEC[0][7:0]);

    // R2 order, R4 per-character flags
    for (int i = 0; i < 8; i++) begin
      chk("R2 head order", head_data, VEC[i][7:0]);
      chk("R4 head flags", st(), VEC[i][10:8]);
      pop();
    end
    chk("R4 empty status", st(), 0);
    chk("R2 empty", head_valid, 0);
    pop();
    chk("R9 empty read fill", fill, 0);
    chk("R3 overrun sticky", overrun, 1);
    err_clr = 1; cyc();
    chk("R3 overrun cleared", overrun, 0);

    // R5 block mode
    block_mode = 1;
    push(11'h1_A1);
    chk("R5 first head", st(), 3'b001);
    push(11'h2_A2);
    chk("R5 non-head not counted", st(), 3'b001);
    pop();
    chk("R5 new head ORed", st(), 3'b011);
    err_clr = 1; cyc();
    chk("R5 cleared, head not recounted", st(), 3'b000);
    pop();
    push(11'h4_A3);
    chk("R5 break head", st(), 3'b100);
    pop();
    chk("R5 sticky when empty", st(), 3'b100);
    err_clr = 1; cyc();
    chk("R5 clear", st(), 3'b000);
    block_mode = 0;

    // R8 manual commands, auto off
    rts_on = 1; cyc();
    chk("R8 rts_on", rts_n, 0);
    for (int i = 0; i < 6; i++) push(VEC[i]);
    start_det = 1; cyc();
    chk("R8 start ignored when auto off", rts_n, 0);

    // R9 below threshold
    auto_rts = 1;
    pop();
    start_det = 1; cyc();
    chk("R9 start below threshold", rts_n, 0);

    // R6 automatic drop
    push(VEC[6]);
    start_det = 1; cyc();
    chk("R6 auto drop", rts_n, 1);
    cyc();
    chk("R7 held at threshold", rts_n, 1);
    pop();
    chk("R7 not yet raised", rts_n, 1);
    cyc();
    chk("R7 auto raise", rts_n, 0);

    rts_off = 1; cyc();
    chk("R8 rts_off", rts_n, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule